// File: doc/BRIEF.md
# Half-Port Pin Interrupt Controller

This block watches two 16-pin input ports and drives one interrupt request line. Internally it works on a 32-bit vector of interrupt bits, split into four 8-bit lanes. Each lane can be pointed at the lower or upper eight pins of either port. Bits 16 to 31 are therefore logical positions: they are copies of physical pins that a lane has selected, not extra pins.

Each bit is set for high level, low level, rising edge or falling edge sensitivity. Two settings together choose the sensitivity: a level/edge mode bit and an invert bit. Edge events are held in a latch until software clears them. Requests that survive the mask are ORed together into the registered `irq_o`. To get an interrupt on both edges of one pin, software routes the same half-port to a lower and an upper lane. It sets the lower copy to rising edge and the copy 16 bits above to falling edge.

Software reaches the block through a simple synchronous register port. The port takes 32-bit accesses and 16-bit accesses. The mask, invert and mode settings each have a set alias and a clear alias, and the latch is cleared by writing 1 to its bits.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset the mask, invert and mode settings are all zero, the lane field reads 0x88 and `irq_o` is low.
- R2: The lane word (register index 8) holds a 2-bit field for lane k (interrupt bits 8k+7..8k) at bits 2k+1..2k. Field bit 0 picks the port (0 = A, 1 = B). Field bit 1 picks the half (0 = pins 7..0, 1 = pins 15..8). Register index 9 reads back the resulting 32-bit pin view.
- R3: With mode bit 0 (level), a bit requests while the pin is high when its invert bit is 0, and while the pin is low when its invert bit is 1. A level request is never latched.
- R4: With mode bit 1 (edge), a rising pin edge sets the latch bit when the invert bit is 0. A falling pin edge sets it when the invert bit is 1. The opposite edge does not set it.
- R5: A latch bit (register index 6) stays set until a 1 is written to that bit at index 6. Writing 0 to it has no effect.
- R6: Writing 1 to a bit of a clear alias clears that setting bit, and writing 0 leaves it unchanged. The set aliases work the same way, setting bits. The aliases are: mask set/clear at indices 0/1, invert set/clear at 2/3, and mode set/clear at 4/5.
- R7: `irq_o` is the registered OR over all 32 bits of (request AND mask). Index 7 reads the unmasked request vector. With the mask all zero, `irq_o` is low on the next cycle.
- R8: Register index n sits at halfword addresses 2n and 2n+1. A 16-bit access (`bus_half_i` = 1) moves data on bits 15..0 to or from the lower half of the register when address bit 0 is 0, and the upper half when it is 1. The other half is left untouched.
- R9: If lanes 0 and 2 select the same half-port, bit n is set to rising edge and bit n+16 is set to falling edge, then a rising pin latches only bit n and a falling pin latches only bit n+16.
- R10: A pin change made between clock edges raises `irq_o` on the third rising edge after it for a level request, and on the fourth for an edge request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| port_a_i | input | 16 | Pins of port A (asynchronous) |
| port_b_i | input | 16 | Pins of port B (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_half_i | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_addr_i | input | 5 | Halfword address; bits 4..1 register index, bit 0 upper half |
| bus_wdata_i | input | 32 | Write data (bits 15..0 for 16-bit writes) |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four properties on every cycle:
- a clear-alias write to the invert setting removes exactly the written bits and leaves the others unchanged;
- a latch bit never drops without a clear write;
- a latch bit only rises for a bit in edge mode;
- an all-zero mask keeps `irq_o` low on the next cycle.

Lane routing, the polarity of each sensitivity, the both-edge configuration on one pin, the exact pin-to-IRQ latency and the half-register accesses depend on stimulus. Only the bench's scenarios show these.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int LANE_W    = 8;
  localparam int NUM_LANES = 4;
  localparam int DATA_W    = LANE_W * NUM_LANES;
  localparam int PORT_W    = 2 * LANE_W;
  localparam int HALF_W    = DATA_W / 2;
  localparam int SEL_W     = 2;
  localparam int SEL_TOT   = SEL_W * NUM_LANES;
  localparam int ADDR_W    = 5;

  localparam logic [3:0] IDX_MASK_SET = 4'd0;
  localparam logic [3:0] IDX_MASK_CLR = 4'd1;
  localparam logic [3:0] IDX_INV_SET  = 4'd2;
  localparam logic [3:0] IDX_INV_CLR  = 4'd3;
  localparam logic [3:0] IDX_MODE_SET = 4'd4;
  localparam logic [3:0] IDX_MODE_CLR = 4'd5;
  localparam logic [3:0] IDX_LATCH    = 4'd6;
  localparam logic [3:0] IDX_REQ      = 4'd7;
  localparam logic [3:0] IDX_LANE     = 4'd8;
  localparam logic [3:0] IDX_VIEW     = 4'd9;

  // even lanes -> low half, odd lanes -> high half, all on port A
  function automatic logic [SEL_TOT-1:0] lane_rst_val();
    logic [SEL_TOT-1:0] r;
    r = '0;
    for (int k = 0; k < NUM_LANES; k++) begin
      r[SEL_W*k]   = 1'b0;
      r[SEL_W*k+1] = k[0];
    end
    return r;
  endfunction
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/pin_irq_lane_mux.sv
module pin_irq_lane_mux
  import pin_irq_pkg::*;
(
  input  logic [PORT_W-1:0]  port_a_i,
  input  logic [PORT_W-1:0]  port_b_i,
  input  logic [SEL_TOT-1:0] lane_sel_i,
  output logic [DATA_W-1:0]  view_o
);
  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    logic [SEL_W-1:0]  sel;
    logic [PORT_W-1:0] port;
    assign sel  = lane_sel_i[SEL_W*k +: SEL_W];
    assign port = sel[0] ? port_b_i : port_a_i;
    assign view_o[LANE_W*k +: LANE_W] = sel[1] ? port[PORT_W-1:LANE_W] : port[LANE_W-1:0];
  end
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] view_i,
  input  logic [W-1:0] inv_i,
  input  logic [W-1:0] mode_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] req_o,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] view_q, latch_q, hit, set_b;

  // edge polarity taken from raw pin, so toggling invert never fakes an edge
  assign hit   = (view_i & ~view_q & ~inv_i) | (~view_i & view_q & inv_i);
  assign set_b = hit & mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      view_q  <= '0;
      latch_q <= '0;
    end else begin
      view_q  <= view_i;
      latch_q <= (latch_q & ~clr_i) | set_b;
    end
  end

  assign req_o   = (mode_i & latch_q) | (~mode_i & (view_i ^ inv_i));
  assign latch_o = latch_q;

  assert_latch_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ($past(latch_q) & ~$past(clr_i))) == ($past(latch_q) & ~$past(clr_i))));

  assert_latch_edge_only_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(mode_i)) == '0));
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               half_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  req_i,
  input  logic [DATA_W-1:0]  latch_i,
  input  logic [DATA_W-1:0]  view_i,
  output logic [DATA_W-1:0]  mask_o,
  output logic [DATA_W-1:0]  inv_o,
  output logic [DATA_W-1:0]  mode_o,
  output logic [DATA_W-1:0]  latch_clr_o,
  output logic [SEL_TOT-1:0] lane_sel_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic [3:0]         idx;
  logic               up;
  logic [DATA_W-1:0]  wd, rd_full;
  logic [DATA_W-1:0]  mask_q, inv_q, mode_q;
  logic [SEL_TOT-1:0] lane_q;

  assign idx = addr_i[ADDR_W-1:1];
  assign up  = addr_i[0];

  // place write data into the addressed half; the other half stays zero
  always_comb begin
    if (!half_i)  wd = wdata_i;
    else if (up)  wd = {wdata_i[HALF_W-1:0], {HALF_W{1'b0}}};
    else          wd = {{HALF_W{1'b0}}, wdata_i[HALF_W-1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      inv_q  <= '0;
      mode_q <= '0;
      lane_q <= lane_rst_val();
    end else if (wr_i) begin
      case (idx)
        IDX_MASK_SET: mask_q <= mask_q | wd;
        IDX_MASK_CLR: mask_q <= mask_q & ~wd;
        IDX_INV_SET:  inv_q  <= inv_q | wd;
        IDX_INV_CLR:  inv_q  <= inv_q & ~wd;
        IDX_MODE_SET: mode_q <= mode_q | wd;
        IDX_MODE_CLR: mode_q <= mode_q & ~wd;
        IDX_LANE:     if (!(half_i && up)) lane_q <= wd[SEL_TOT-1:0];
        default: ;
      endcase
    end
  end

  assign latch_clr_o = (wr_i && idx == IDX_LATCH) ? wd : '0;

  always_comb begin
    case (idx)
      IDX_MASK_SET, IDX_MASK_CLR: rd_full = mask_q;
      IDX_INV_SET,  IDX_INV_CLR:  rd_full = inv_q;
      IDX_MODE_SET, IDX_MODE_CLR: rd_full = mode_q;
      IDX_LATCH:                  rd_full = latch_i;
      IDX_REQ:                    rd_full = req_i;
      IDX_LANE:                   rd_full = {{(DATA_W-SEL_TOT){1'b0}}, lane_q};
      IDX_VIEW:                   rd_full = view_i;
      default:                    rd_full = '0;
    endcase
    if (!half_i)  rdata_o = rd_full;
    else if (up)  rdata_o = {{HALF_W{1'b0}}, rd_full[DATA_W-1:HALF_W]};
    else          rdata_o = {{HALF_W{1'b0}}, rd_full[HALF_W-1:0]};
  end

  assign mask_o     = mask_q;
  assign inv_o      = inv_q;
  assign mode_o     = mode_q;
  assign lane_sel_o = lane_q;

  assert_inv_clr_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !half_i && idx == IDX_INV_CLR) |=> ((inv_q & $past(wdata_i)) == '0));

  assert_inv_clr_zeros_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !half_i && idx == IDX_INV_CLR) |=> ((inv_q & ~$past(wdata_i)) == ($past(inv_q) & ~$past(wdata_i))));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] port_a_i,
  input  logic [PORT_W-1:0] port_b_i,
  input  logic              bus_wr_i,
  input  logic              bus_half_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  logic [PORT_W-1:0]  a_sync, b_sync;
  logic [SEL_TOT-1:0] lane_sel;
  logic [DATA_W-1:0]  view, mask, inv, mode, latch_clr, req, latch;
  logic               irq_q;

  pin_irq_sync #(.W(PORT_W)) u_sync_a (.clk_i, .rst_ni, .d_i(port_a_i), .q_o(a_sync));
  pin_irq_sync #(.W(PORT_W)) u_sync_b (.clk_i, .rst_ni, .d_i(port_b_i), .q_o(b_sync));

  pin_irq_lane_mux u_lane (
    .port_a_i(a_sync), .port_b_i(b_sync), .lane_sel_i(lane_sel), .view_o(view)
  );

  pin_irq_detect #(.W(DATA_W)) u_detect (
    .clk_i, .rst_ni, .view_i(view), .inv_i(inv), .mode_i(mode),
    .clr_i(latch_clr), .req_o(req), .latch_o(latch)
  );

  pin_irq_regs u_regs (
    .clk_i, .rst_ni, .wr_i(bus_wr_i), .half_i(bus_half_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .req_i(req), .latch_i(latch), .view_i(view),
    .mask_o(mask), .inv_o(inv), .mode_o(mode), .latch_clr_o(latch_clr),
    .lane_sel_o(lane_sel), .rdata_o(bus_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(req & mask);
  end

  assign irq_o = irq_q;

  assert_mask_zero_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask == '0) |=> !irq_o);
endmodule

// File: tb/pin_irq_ctrl_tb.sv
`timescale 1ns/1ps
module pin_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] port_a = '0, port_b = '0;
  logic        wr = 1'b0, half = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0, rdata, rv;
  logic        irq;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  localparam logic [4:0] A_MASK_SET = 5'd0,  A_MASK_CLR = 5'd2,  A_INV_SET = 5'd4;
  localparam logic [4:0] A_INV_CLR  = 5'd6,  A_MODE_SET = 5'd8,  A_MODE_CLR = 5'd10;
  localparam logic [4:0] A_LATCH    = 5'd12, A_REQ      = 5'd14, A_LANE    = 5'd16;
  localparam logic [4:0] A_VIEW     = 5'd18;

  // {lane_sel, port_a, port_b, expected view}
  localparam logic [71:0] VEC [5] = '{
    {8'h88, 16'hA5C3, 16'h3C96, 32'hA5C3A5C3},
    {8'hD8, 16'hA5C3, 16'h3C96, 32'h3C96A5C3},
    {8'h27, 16'hA5C3, 16'h3C96, 32'hC3A5963C},
    {8'h00, 16'h0F01, 16'hFFFF, 32'h01010101},
    {8'h55, 16'h1234, 16'hABCD, 32'hCDCDCDCD}
  };

  pin_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .port_a_i(port_a), .port_b_i(port_b),
    .bus_wr_i(wr), .bus_half_i(half), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d, input logic h);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d; half = h;
    @(negedge clk);
    wr = 1'b0; half = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [4:0] a, input logic h, output logic [31:0] d);
    @(negedge clk);
    addr = a; half = h;
    #1 d = rdata;
    half = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    check({31'b0, irq}, 32'd0, "R1 irq");
    bus_read(A_MASK_SET, 1'b0, rv); check(rv, 32'h0, "R1 mask");
    bus_read(A_INV_SET, 1'b0, rv);  check(rv, 32'h0, "R1 inv");
    bus_read(A_MODE_SET, 1'b0, rv); check(rv, 32'h0, "R1 mode");
    bus_read(A_LANE, 1'b0, rv);     check(rv, 32'h88, "R1 lane");

    // R2 lane routing table
    for (int i = 0; i < 5; i++) begin
      bus_write(A_LANE, {24'h0, VEC[i][71:64]}, 1'b0);
      port_a = VEC[i][63:48];
      port_b = VEC[i][47:32];
      wait_cyc(4);
      bus_read(A_VIEW, 1'b0, rv);
      check(rv, VEC[i][31:0], $sformatf("R2 vec%0d", i));
    end
    port_a = '0; port_b = '0;
    bus_write(A_LANE, 32'h88, 1'b0);
    wait_cyc(4);

    // R3 level, R10 latency
    bus_write(A_MASK_SET, 32'h1, 1'b0);
    wait_cyc(3);
    check({31'b0, irq}, 32'd0, "R3 low pin no req");
    @(negedge clk) port_a[0] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) check({31'b0, irq}, 32'd0, "R10 level not yet");
    @(posedge clk);
    @(negedge clk) check({31'b0, irq}, 32'd1, "R10 R3 level high");
    port_a[0] = 1'b0;
    wait_cyc(4);
    check({31'b0, irq}, 32'd0, "R3 level drops");
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h0, "R3 no latch");
    bus_write(A_INV_SET, 32'h1, 1'b0);
    wait_cyc(3);
    check({31'b0, irq}, 32'd1, "R3 low level");
    bus_write(A_INV_CLR, 32'h0, 1'b0);
    bus_read(A_INV_SET, 1'b0, rv); check(rv, 32'h1, "R6 clr zero no effect");
    bus_write(A_INV_CLR, 32'h1, 1'b0);
    bus_read(A_INV_SET, 1'b0, rv); check(rv, 32'h0, "R6 clr one");
    wait_cyc(3);
    check({31'b0, irq}, 32'd0, "R3 inv removed");

    // R4 rising edge, R5 latch hold/clear
    bus_write(A_MODE_SET, 32'h1, 1'b0);
    bus_write(A_LATCH, 32'hFFFF_FFFF, 1'b0);
    wait_cyc(2);
    @(negedge clk) port_a[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk) check({31'b0, irq}, 32'd0, "R10 edge not yet");
    @(posedge clk);
    @(negedge clk) check({31'b0, irq}, 32'd1, "R10 R4 rising");
    port_a[0] = 1'b0;
    wait_cyc(4);
    check({31'b0, irq}, 32'd1, "R5 held after pin low");
    bus_write(A_LATCH, 32'h0, 1'b0);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h1, "R5 zero write no effect");
    bus_write(A_LATCH, 32'h1, 1'b0);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h0, "R5 cleared");
    wait_cyc(2);
    check({31'b0, irq}, 32'd0, "R5 irq released");

    // R4 falling edge, R7 masking
    bus_write(A_INV_SET, 32'h1, 1'b0);
    port_a[0] = 1'b1;
    wait_cyc(5);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h0, "R4 rise ignored when falling");
    port_a[0] = 1'b0;
    wait_cyc(5);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h1, "R4 falling latched");
    bus_write(A_MASK_CLR, 32'h1, 1'b0);
    wait_cyc(2);
    check({31'b0, irq}, 32'd0, "R7 masked");
    bus_read(A_REQ, 1'b0, rv); check(rv & 32'h1, 32'h1, "R7 req visible");
    bus_write(A_MASK_SET, 32'h1, 1'b0);
    wait_cyc(2);
    check({31'b0, irq}, 32'd1, "R7 unmasked");
    bus_write(A_MODE_CLR, 32'hFFFF_FFFF, 1'b0);
    bus_write(A_INV_CLR, 32'hFFFF_FFFF, 1'b0);
    bus_write(A_LATCH, 32'hFFFF_FFFF, 1'b0);
    bus_write(A_MASK_CLR, 32'hFFFF_FFFF, 1'b0);
    bus_read(A_MODE_SET, 1'b0, rv); check(rv, 32'h0, "R6 mode clr");

    // R8 16-bit accesses
    bus_write(A_MASK_SET + 5'd1, 32'h0000_0001, 1'b1);
    bus_read(A_MASK_SET, 1'b0, rv);        check(rv, 32'h0001_0000, "R8 upper write");
    bus_read(A_MASK_SET + 5'd1, 1'b1, rv); check(rv, 32'h1, "R8 upper read");
    bus_read(A_MASK_SET, 1'b1, rv);        check(rv, 32'h0, "R8 lower read");
    bus_write(A_LANE, 32'h0000_00D8, 1'b1);
    bus_read(A_LANE, 1'b0, rv); check(rv, 32'hD8, "R8 lane lower write");
    bus_write(A_LANE + 5'd1, 32'h0000_FFFF, 1'b1);
    bus_read(A_LANE, 1'b0, rv); check(rv, 32'hD8, "R8 lane upper untouched");
    bus_write(A_LANE, 32'h88, 1'b0);
    bus_write(A_MASK_CLR, 32'hFFFF_FFFF, 1'b0);

    // R9 both edges on one pin through lanes 0 and 2
    port_a = '0;
    wait_cyc(4);
    bus_write(A_MODE_SET, 32'h0001_0001, 1'b0);
    bus_write(A_INV_SET, 32'h0001_0000, 1'b0);
    bus_write(A_LATCH, 32'hFFFF_FFFF, 1'b0);
    bus_write(A_MASK_SET, 32'h0001_0001, 1'b0);
    port_a[0] = 1'b1;
    wait_cyc(5);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h0000_0001, "R9 rise lower copy");
    check({31'b0, irq}, 32'd1, "R9 irq on rise");
    bus_write(A_LATCH, 32'hFFFF_FFFF, 1'b0);
    wait_cyc(2);
    check({31'b0, irq}, 32'd0, "R9 irq cleared");
    port_a[0] = 1'b0;
    wait_cyc(5);
    bus_read(A_LATCH, 1'b0, rv); check(rv, 32'h0001_0000, "R9 fall upper copy");
    check({31'b0, irq}, 32'd1, "R9 irq on fall");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule